// File: doc/BRIEF.md
# Flash Interface Control Status Register

This block is the 8-bit control and status register of a flash memory interface. Software uses it to allow or forbid program and erase strobes toward the flash array, to pick a low-power mode, and to learn when the embedded program/erase algorithm has finished. A one-cycle completion pulse from the algorithm engine sets a sticky ready-interrupt flag. Software clears that flag by writing 0 to it. Together with an enable bit, the flag drives a level interrupt request.

The flag's lifecycle is held in a three-state machine:
- `ST_IDLE` is the state after reset and after software has cleared the flag. The flag reads 0 and the write gate is open.
- `ST_RUN` means an operation is in flight. The flag reads 0 and the gate is closed.
- `ST_DONE` means the operation has finished. The flag reads 1 and the gate is open.

The transitions are:
- IDLE→RUN and DONE→RUN when a gated strobe passes.
- IDLE→DONE, RUN→DONE and DONE→DONE on a completion pulse. The pulse takes priority over every other event.
- DONE→IDLE when software writes 0 to the flag.

The flag reads as 1 on read-modify-write reads, so that a read-modify-write sequence on other bits never clears it by accident.

Top module: `flash_csr`

## Requirements
- R1: After reset the register reads 0x10 while the engine's ready level is 1. The interrupt request and the flash strobe output are both 0.
- R2: Bit 4 mirrors the engine's ready level and ignores writes. Bits 3 and 1 always read 0.
- R3: The interrupt output is a register loaded each cycle with the AND of the enable bit (bit 7) and the ready flag (bit 6). It follows a change one cycle late and never asserts while the enable bit is 0.
- R4: A completion pulse sets the ready flag (bit 6) for the next cycle. This holds even when a write of 0 to bit 6 arrives in the same cycle.
- R5: Writing 0 to bit 6 clears the flag. Writing 1 to bit 6 leaves it unchanged.
- R6: On a read with the read-modify-write qualifier high, bit 6 reads 1 whatever the flag holds. A plain read returns the stored flag.
- R7: While the write-enable bit (bit 5) is 0, no flash strobe is output. While it is 1 and the gate is open, the raw strobe passes through combinationally in the same cycle.
- R8: Once a strobe has passed, further raw strobes are blocked until a completion pulse sets the flag.
- R9: The enable (bit 7), write-enable (bit 5), low-power bit 1 (bit 2) and low-power bit 0 (bit 0) are read/write and reset to 0.
- R10: Only address REG_ADDR (default 0x0000AE) is decoded. Writes to other addresses have no effect, and reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | CPU byte address |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | CPU read strobe |
| bus_rmw | input | 1 | Read is part of a read-modify-write |
| bus_rdata | output | 8 | CPU read data (combinational) |
| alg_done | input | 1 | One-cycle completion pulse from the algorithm engine |
| alg_ready | input | 1 | Ready level from the algorithm engine |
| raw_flash_wr | input | 1 | Flash write strobe after command decoding |
| flash_wr | output | 1 | Gated flash write/erase strobe |
| irq | output | 1 | Completion interrupt request (level) |

## Verification
The strobe gate is tried in four conditions, and each shows whether a different term is missing from the gate:
- write-enable at 0;
- write-enable at 1 in the idle state;
- a second strobe while an operation runs;
- a strobe after completion.

The flag is written with 0 and with 1 in both the idle and done states. This separates write-0-to-clear from plain storage and from write-1-to-set. A completion pulse is also made to collide with a clearing write, which shows whether the priority is right. Plain reads and read-modify-write reads of the same stored value show whether the qualifier forces bit 6. Toggling the enable bit around a set flag shows the one-cycle latency of the interrupt register.

// File: rtl/flash_csr_pkg.sv
package flash_csr_pkg;
    localparam int CSR_W     = 8;
    localparam int B_INTE    = 7;
    localparam int B_FLAG    = 6;
    localparam int B_WREN    = 5;
    localparam int B_RDY     = 4;
    localparam int B_LPM1    = 2;
    localparam int B_LPM0    = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } op_state_e;
endpackage

// File: rtl/flash_csr_fsm.sv
module flash_csr_fsm
    import flash_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    input  logic done_pulse,
    input  logic raw_wr,
    input  logic wr_enable,
    output logic flag,
    output logic gated_wr
);
    op_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (done_pulse)    state_d = ST_DONE;
                     else if (gated_wr) state_d = ST_RUN;
            ST_RUN:  if (done_pulse)    state_d = ST_DONE;
            ST_DONE: if (done_pulse)    state_d = ST_DONE;
                     else if (gated_wr) state_d = ST_RUN;
                     else if (clr_req)  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        flag     = (state_q == ST_DONE);
        gated_wr = raw_wr && wr_enable && (state_q != ST_RUN);
    end

    p_set_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> flag);
    p_clear_w0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !done_pulse && flag) |=> !flag);
    p_gate_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |-> !gated_wr);
    p_block_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_wr && !done_pulse) |=> !gated_wr);
endmodule

// File: rtl/flash_csr_regs.sv
module flash_csr_regs
    import flash_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             rd_hit,
    input  logic             rmw,
    input  logic [CSR_W-1:0] wdata,
    input  logic             flag,
    input  logic             ready_lvl,
    output logic             inte,
    output logic             wr_enable,
    output logic [CSR_W-1:0] rdata
);
    logic lpm1_q, lpm0_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inte      <= 1'b0;
            wr_enable <= 1'b0;
            lpm1_q    <= 1'b0;
            lpm0_q    <= 1'b0;
        end else if (wr_hit) begin
            inte      <= wdata[B_INTE];
            wr_enable <= wdata[B_WREN];
            lpm1_q    <= wdata[B_LPM1];
            lpm0_q    <= wdata[B_LPM0];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata[B_INTE] = inte;
            rdata[B_FLAG] = flag | rmw;
            rdata[B_WREN] = wr_enable;
            rdata[B_RDY]  = ready_lvl;
            rdata[B_LPM1] = lpm1_q;
            rdata[B_LPM0] = lpm0_q;
        end
    end

    p_rdy_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (rdata[B_RDY] == ready_lvl && rdata[3] == 1'b0 && rdata[1] == 1'b0));
    p_rmw_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rmw) |-> rdata[B_FLAG]);
endmodule

// File: rtl/flash_csr.sv
module flash_csr
    import flash_csr_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] REG_ADDR = 24'h0000AE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CSR_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              alg_done,
    input  logic              alg_ready,
    input  logic              raw_flash_wr,
    output logic              flash_wr,
    output logic              irq
);
    logic sel, wr_hit, rd_hit, flag, inte, wr_enable;

    assign sel    = (bus_addr == REG_ADDR);
    assign wr_hit = sel && bus_wr;
    assign rd_hit = sel && bus_rd;

    flash_csr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_req    (wr_hit && !bus_wdata[B_FLAG]),
        .done_pulse (alg_done),
        .raw_wr     (raw_flash_wr),
        .wr_enable  (wr_enable),
        .flag       (flag),
        .gated_wr   (flash_wr)
    );

    flash_csr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .rmw       (bus_rmw),
        .wdata     (bus_wdata),
        .flag      (flag),
        .ready_lvl (alg_ready),
        .inte      (inte),
        .wr_enable (wr_enable),
        .rdata     (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= inte && flag;
    end

    p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(inte && flag));
    p_w1_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_wdata[B_FLAG] && !flag && !alg_done) |=> !flag);
    p_miss_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (bus_rdata == '0));
endmodule

// File: tb/tb_flash_csr.sv
module tb_flash_csr;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] CSR_ADDR = 24'h0000AE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = CSR_ADDR;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_rmw = 1'b0;
    logic [7:0]  bus_rdata;
    logic        alg_done = 1'b0;
    logic        alg_ready = 1'b1;
    logic        raw_flash_wr = 1'b0;
    logic        flash_wr;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_csr dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
        .bus_rdata(bus_rdata), .alg_done(alg_done), .alg_ready(alg_ready),
        .raw_flash_wr(raw_flash_wr), .flash_wr(flash_wr), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [23:0] a, input logic [7:0] d, input logic with_done);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; alg_done = with_done;
        tick();
        bus_wr = 1'b0; alg_done = 1'b0; bus_addr = CSR_ADDR;
    endtask

    task automatic rd_reg(input logic [23:0] a, input logic rmw, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1; bus_rmw = rmw;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_rmw = 1'b0; bus_addr = CSR_ADDR;
    endtask

    task automatic pulse_done();
        alg_done = 1'b1;
        tick();
        alg_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R1 reset value", d, 8'h10);
        check("R1 irq at reset", {7'd0, irq}, 8'h00);
        check("R1 strobe at reset", {7'd0, flash_wr}, 8'h00);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        alg_ready = 1'b0;
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R2 ready level low", d, 8'h00);
        wr_reg(CSR_ADDR, 8'hFF, 1'b0);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R9/R5/R2 write all ones (flag, rdy, reserved unchanged)", d, 8'hA5);
        alg_ready = 1'b1;
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R2 ready level high", d, 8'hB5);
        wr_reg(CSR_ADDR, 8'h00, 1'b0);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R9 write zeros", d, 8'h10);
    endtask

    task automatic t_gate();
        logic [7:0] d;
        raw_flash_wr = 1'b1;
        #1 check("R7 we=0 blocks strobe", {7'd0, flash_wr}, 8'h00);
        tick();
        raw_flash_wr = 1'b0;
        wr_reg(CSR_ADDR, 8'h20, 1'b0);
        raw_flash_wr = 1'b1;
        #1 check("R7 we=1 passes strobe", {7'd0, flash_wr}, 8'h01);
        tick();
        #1 check("R8 strobe blocked while running", {7'd0, flash_wr}, 8'h00);
        raw_flash_wr = 1'b0;
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R8 flag low while running", d, 8'h30);
        pulse_done();
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R4 completion sets flag", d, 8'h70);
        raw_flash_wr = 1'b1;
        #1 check("R8 strobe allowed after completion", {7'd0, flash_wr}, 8'h01);
        tick();
        raw_flash_wr = 1'b0;
        pulse_done();
    endtask

    task automatic t_irq();
        logic [7:0] d;
        pulse_done();
        check("R3 no irq with enable clear", {7'd0, irq}, 8'h00);
        wr_reg(CSR_ADDR, 8'hE0, 1'b0);
        check("R3 irq lags enable by one cycle", {7'd0, irq}, 8'h00);
        tick();
        check("R3 irq asserted", {7'd0, irq}, 8'h01);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R5 write of 1 keeps flag", d, 8'hF0);
        wr_reg(CSR_ADDR, 8'hA0, 1'b0);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R5 write of 0 clears flag", d, 8'hB0);
        check("R3 irq still high one cycle", {7'd0, irq}, 8'h01);
        tick();
        check("R3 irq drops after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_rmw();
        logic [7:0] d;
        rd_reg(CSR_ADDR, 1'b1, d);
        check("R6 rmw read forces flag", d, 8'hF0);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R6 plain read shows stored flag", d, 8'hB0);
        wr_reg(CSR_ADDR, 8'hF0, 1'b0);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R6 rmw write-back does not set flag", d, 8'hB0);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        pulse_done();
        wr_reg(CSR_ADDR, 8'h00, 1'b1);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R4 completion beats clear", d, 8'h50);
        wr_reg(CSR_ADDR, 8'h00, 1'b0);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R5 clear after collision", d, 8'h10);
    endtask

    task automatic t_addr();
        logic [7:0] d;
        wr_reg(24'h0000AF, 8'hFF, 1'b0);
        rd_reg(CSR_ADDR, 1'b0, d);
        check("R10 other address write ignored", d, 8'h10);
        rd_reg(24'h0000AD, 1'b1, d);
        check("R10 other address reads zero", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_gate();
        t_irq();
        t_rmw();
        t_priority();
        t_addr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule